// File: doc/BRIEF.md
# Serial Receive Frame Classifier

This block is the receive half of an asynchronous serial port. It watches a single serial line, using a 16x oversampling tick to confirm start bits and to pick the middle of each bit. It reassembles characters of five to eight data bits, with an optional ninth bit and one or two stop bits. Each completed character is written into a 16-entry receive queue together with four status flags: framing error, parity error (or address marker), line break and overrun.

The ninth bit has two uses. With parity checking on, it is the parity bit and is checked against the data. In nine-bit mode it tags the character as an address (1) or as data (0), and no parity check is made. When the queue is full, completed characters are dropped. The loss is reported twice: by a sticky overrun status that software clears by writing a 1, and by a marker on the first character that is stored after the loss.

Top module: `serial_rx_tagger`

## Requirements
- R1: After synchronous reset the queue is empty (`rd_valid`=0, `fifo_full`=0) and `ovr_sticky` is 0.
- R2: Data is received least significant bit first, with 5 + `cfg_data_bits` data bits (code 0..3 gives 5..8 bits). A queue entry holds the data in bits [7:0] with unused upper bits zero, the framing flag in bit 8, the parity/address flag in bit 9, the break flag in bit 10 and the overrun flag in bit 11.
- R3: A low level on the line that reads high again at the eighth oversampling tick after it is seen is rejected as a glitch and produces no entry.
- R4: The framing flag is set when any configured stop bit (one, or two when `cfg_two_stop`=1) is sampled as 0.
- R5: With `cfg_nine_bit`=0 and `cfg_par_en`=1, a ninth bit follows the data. The parity/address flag is set when the count of ones in data plus that bit is odd for even parity (`cfg_par_odd`=0), or even for odd parity (`cfg_par_odd`=1).
- R6: With `cfg_nine_bit`=1, a ninth bit always follows the data and no parity check is made. The parity/address flag equals the received ninth bit.
- R7: A character whose every bit (start, data, ninth, stops) is 0 sets the break flag and the framing flag. The receiver then accepts no new start bit until the line has returned to 1.
- R8: The queue holds 16 entries in arrival order. `fifo_full` is high when it holds 16. `rd_data` shows the oldest entry while `rd_valid`=1. `rd_pop` removes it, and a pop on an empty queue has no effect.
- R9: A character that completes while the queue is full, with no pop in that cycle, is discarded and sets `ovr_sticky`.
- R10: The first character stored after one or more discarded characters has its overrun flag set. Later characters do not.
- R11: `ovr_sticky` stays at 1 until `ovr_clr`=1 clears it. A discard in the same cycle as a clear leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| cfg_data_bits | input | 2 | Data length code, bits = 5 + code |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_nine_bit | input | 1 | Ninth bit is an address marker |
| rd_pop | input | 1 | Remove the oldest queue entry |
| ovr_clr | input | 1 | Write-one clear of the sticky overrun |
| rd_data | output | 12 | Oldest queue entry |
| rd_valid | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue holds 16 entries |
| ovr_sticky | output | 1 | Sticky overrun status |

## Verification
Setting the sticky overrun because a character is discarded and clearing it from software can happen in the same cycle. The bench provokes this by filling the queue, holding `ovr_clr` at 1 for the whole of one more character, and watching `ovr_sticky` at every cycle. It passes only if the status is seen at 1 for at least one cycle and is 0 once the clear is released. The bench then drains the queue and checks that the next stored character still carries the overrun marker, which shows that the clear left the per-character marker alone.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_W  = 8;
    localparam int ENTRY_W = DATA_W + 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_NINTH,
        S_STOP,
        S_BRKWAIT
    } rx_state_e;

    // Raw result of one deserialized character
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ninth;
        logic              stop_ok;
        logic              any_one;
    } raw_frame_t;

    // Queue entry, MSB first: ovr, brk, par_addr, frm, data
    typedef struct packed {
        logic              ovr;
        logic              brk;
        logic              par_addr;
        logic              frm;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    function automatic logic [3:0] data_len(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic parity_flag(input logic [DATA_W-1:0] d,
                                         input logic ninth,
                                         input logic odd);
        return ninth != ((^d) ^ odd);
    endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
    import srx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_line,
    input  logic       os_tick,
    input  logic [1:0] cfg_data_bits,
    input  logic       cfg_two_stop,
    input  logic       cfg_has_ninth,
    output logic       frame_valid,
    output raw_frame_t frame
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    rx_state_e              state;
    logic [CNT_W-1:0]       cnt;
    logic [2:0]             bit_idx;
    logic                   stop_idx;
    logic [DATA_W-1:0]      data_q;
    logic                   ninth_q;
    logic                   stop_ok_q;
    logic                   any_one_q;
    logic [3:0]             nbits;

    assign nbits = data_len(cfg_data_bits);
    assign rx_s  = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            cnt         <= '0;
            bit_idx     <= '0;
            stop_idx    <= 1'b0;
            data_q      <= '0;
            ninth_q     <= 1'b0;
            stop_ok_q   <= 1'b1;
            any_one_q   <= 1'b0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (os_tick && !rx_s) begin
                        state <= S_START;
                        cnt   <= '0;
                    end
                end
                S_START: begin
                    if (os_tick) begin
                        if (cnt == MID) begin
                            if (rx_s) begin
                                state <= S_IDLE;
                            end else begin
                                state     <= S_DATA;
                                cnt       <= '0;
                                bit_idx   <= '0;
                                data_q    <= '0;
                                ninth_q   <= 1'b0;
                                stop_ok_q <= 1'b1;
                                any_one_q <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    if (os_tick) begin
                        if (cnt == LAST) begin
                            cnt             <= '0;
                            data_q[bit_idx] <= rx_s;
                            any_one_q       <= any_one_q | rx_s;
                            if ({1'b0, bit_idx} == nbits - 4'd1) begin
                                state    <= cfg_has_ninth ? S_NINTH : S_STOP;
                                stop_idx <= 1'b0;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_NINTH: begin
                    if (os_tick) begin
                        if (cnt == LAST) begin
                            cnt       <= '0;
                            ninth_q   <= rx_s;
                            any_one_q <= any_one_q | rx_s;
                            state     <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_STOP: begin
                    if (os_tick) begin
                        if (cnt == LAST) begin
                            cnt       <= '0;
                            stop_ok_q <= stop_ok_q & rx_s;
                            any_one_q <= any_one_q | rx_s;
                            if (stop_idx || !cfg_two_stop) begin
                                frame_valid <= 1'b1;
                                state <= (any_one_q | rx_s) ? S_IDLE : S_BRKWAIT;
                            end else begin
                                stop_idx <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_BRKWAIT: begin
                    if (rx_s) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign frame = '{data: data_q, ninth: ninth_q, stop_ok: stop_ok_q, any_one: any_one_q};

endmodule

// File: rtl/srx_classify.sv
module srx_classify
    import srx_pkg::*;
(
    input  raw_frame_t frame,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_nine_bit,
    output rx_entry_t  entry
);
    always_comb begin
        entry.data = frame.data;
        entry.frm  = !frame.stop_ok;
        entry.brk  = !frame.any_one;
        entry.ovr  = 1'b0;
        if (cfg_nine_bit)
            entry.par_addr = frame.ninth;
        else if (cfg_par_en)
            entry.par_addr = parity_flag(frame.data, frame.ninth, cfg_par_odd);
        else
            entry.par_addr = 1'b0;
    end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             pop_eff, push_eff;

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign pop_eff  = pop && !empty;
    assign push_eff = push && (!full || pop_eff);
    assign dout     = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_eff) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_eff) wptr <= wptr + 1'b1;
            if (pop_eff)  rptr <= rptr + 1'b1;
            case ({push_eff, pop_eff})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/srx_ovr_track.sv
module srx_ovr_track (
    input  logic clk,
    input  logic rst,
    input  logic frame_valid,
    input  logic fifo_full,
    input  logic pop,
    input  logic ovr_clr,
    output logic store,
    output logic drop,
    output logic ovr_pend,
    output logic ovr_sticky
);
    assign store = frame_valid && (!fifo_full || pop);
    assign drop  = frame_valid && fifo_full && !pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_pend   <= 1'b0;
            ovr_sticky <= 1'b0;
        end else begin
            if (drop)       ovr_pend <= 1'b1;
            else if (store) ovr_pend <= 1'b0;

            if (drop)         ovr_sticky <= 1'b1;
            else if (ovr_clr) ovr_sticky <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_tagger.sv
module serial_rx_tagger
    import srx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_line,
    input  logic               os_tick,
    input  logic [1:0]         cfg_data_bits,
    input  logic               cfg_two_stop,
    input  logic               cfg_par_en,
    input  logic               cfg_par_odd,
    input  logic               cfg_nine_bit,
    input  logic               rd_pop,
    input  logic               ovr_clr,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               rd_valid,
    output logic               fifo_full,
    output logic               ovr_sticky
);
    logic       frame_valid;
    raw_frame_t frame;
    rx_entry_t  ent_cls;
    rx_entry_t  ent_store;
    logic       store, drop, ovr_pend;
    logic       fifo_empty;
    logic       pop_eff;

    assign rd_valid = !fifo_empty;
    assign pop_eff  = rd_pop && !fifo_empty;

    srx_sampler #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk           (clk),
        .rst           (rst),
        .rx_line       (rx_line),
        .os_tick       (os_tick),
        .cfg_data_bits (cfg_data_bits),
        .cfg_two_stop  (cfg_two_stop),
        .cfg_has_ninth (cfg_par_en | cfg_nine_bit),
        .frame_valid   (frame_valid),
        .frame         (frame)
    );

    srx_classify u_classify (
        .frame        (frame),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_nine_bit (cfg_nine_bit),
        .entry        (ent_cls)
    );

    srx_ovr_track u_ovr (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (frame_valid),
        .fifo_full   (fifo_full),
        .pop         (pop_eff),
        .ovr_clr     (ovr_clr),
        .store       (store),
        .drop        (drop),
        .ovr_pend    (ovr_pend),
        .ovr_sticky  (ovr_sticky)
    );

    always_comb begin
        ent_store     = ent_cls;
        ent_store.ovr = ovr_pend;
    end

    srx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (store),
        .din   (ent_store),
        .pop   (rd_pop),
        .dout  (rd_data),
        .empty (fifo_empty),
        .full  (fifo_full)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic clk,
    input logic rst,
    input logic rd_valid,
    input logic fifo_full,
    input logic ovr_sticky,
    input logic ovr_clr,
    input logic store,
    input logic drop,
    input logic ovr_pend
);
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid && !ovr_sticky));

    a_r8_full_has_data: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> rd_valid);

    a_r9_drop_only_when_full: assert property (@(posedge clk) disable iff (rst)
        drop |-> fifo_full);

    a_r9_store_or_drop: assert property (@(posedge clk) disable iff (rst)
        !(store && drop));

    a_r9_drop_sets_sticky: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovr_sticky);

    a_r10_drop_arms_marker: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovr_pend);

    a_r10_store_takes_marker: assert property (@(posedge clk) disable iff (rst)
        store |=> !ovr_pend);

    a_r11_clear_works: assert property (@(posedge clk) disable iff (rst)
        (ovr_clr && !drop) |=> !ovr_sticky);

    a_r11_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        (ovr_sticky && !ovr_clr) |=> ovr_sticky);
endmodule

bind serial_rx_tagger srx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_valid   (rd_valid),
    .fifo_full  (fifo_full),
    .ovr_sticky (ovr_sticky),
    .ovr_clr    (ovr_clr),
    .store      (store),
    .drop       (drop),
    .ovr_pend   (ovr_pend)
);

// File: tb/serial_rx_tagger_tb.sv
module serial_rx_tagger_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic        os_tick = 1'b0;
    logic [1:0]  cfg_data_bits = 2'd3;
    logic        cfg_two_stop = 1'b0;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic        cfg_nine_bit = 1'b0;
    logic        rd_pop = 1'b0;
    logic        ovr_clr = 1'b0;
    logic [11:0] rd_data;
    logic        rd_valid, fifo_full, ovr_sticky;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    localparam int BIT_CYC = 32;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (rst) os_tick <= 1'b0;
        else     os_tick <= ~os_tick;
    end

    serial_rx_tagger u_dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .os_tick(os_tick),
        .cfg_data_bits(cfg_data_bits), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_nine_bit(cfg_nine_bit), .rd_pop(rd_pop), .ovr_clr(ovr_clr),
        .rd_data(rd_data), .rd_valid(rd_valid), .fifo_full(fifo_full),
        .ovr_sticky(ovr_sticky)
    );

    task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FIFO-CHECK FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] ent(input bit ovr, input bit brk, input bit par,
                                        input bit frm, input logic [7:0] d);
        return {ovr, brk, par, frm, d};
    endfunction

    function automatic logic [15:0] mk(input logic [7:0] d, input int n, input bit has9,
                                       input bit b9, input int nstop, input bit s1, input bit s2);
        logic [15:0] v;
        int p;
        v = '0;
        p = 1;
        for (int i = 0; i < n; i++) begin v[p] = d[i]; p++; end
        if (has9) begin v[p] = b9; p++; end
        v[p] = s1; p++;
        if (nstop == 2) v[p] = s2;
        return v;
    endfunction

    task automatic set_cfg(input logic [1:0] db, input bit two, input bit pen, input bit podd, input bit nine);
        cfg_data_bits = db; cfg_two_stop = two; cfg_par_en = pen;
        cfg_par_odd = podd; cfg_nine_bit = nine;
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] bits, input int len, input bit short_last);
        for (int i = 0; i < len; i++) begin
            rx_line = bits[i];
            repeat ((short_last && i == len - 1) ? 20 : BIT_CYC) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic send8(input logic [7:0] d);
        send(mk(d, 8, 0, 0, 1, 1, 0), 10, 0);
    endtask

    task automatic pop_expect(input string req, input logic [11:0] exp);
        chk({req, " valid"}, rd_valid == 1'b1, 32'(rd_valid), 32'd1);
        chk({req, " entry"}, rd_data == exp, 32'(rd_data), 32'(exp));
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 rd_valid", rd_valid == 1'b0, 32'(rd_valid), 32'd0);
        chk("R1 fifo_full", fifo_full == 1'b0, 32'(fifo_full), 32'd0);
        chk("R1 ovr_sticky", ovr_sticky == 1'b0, 32'(ovr_sticky), 32'd0);
    endtask

    task automatic t_basic();
        set_cfg(2'd3, 0, 0, 0, 0);
        send8(8'hA5);
        pop_expect("R2 8N1 A5", ent(0, 0, 0, 0, 8'hA5));
        send8(8'h3C);
        send8(8'h81);
        pop_expect("R8 order first", ent(0, 0, 0, 0, 8'h3C));
        pop_expect("R8 order second", ent(0, 0, 0, 0, 8'h81));
        rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0; @(negedge clk);
        chk("R8 pop on empty", rd_valid == 1'b0, 32'(rd_valid), 32'd0);
        send8(8'h42);
        pop_expect("R8 after empty pop", ent(0, 0, 0, 0, 8'h42));
    endtask

    task automatic t_width();
        set_cfg(2'd0, 0, 0, 0, 0);
        send(mk(8'hFB, 5, 0, 0, 1, 1, 0), 7, 0);
        pop_expect("R2 5-bit", ent(0, 0, 0, 0, 8'h1B));
        set_cfg(2'd1, 0, 0, 0, 0);
        send(mk(8'hEA, 6, 0, 0, 1, 1, 0), 8, 0);
        pop_expect("R2 6-bit", ent(0, 0, 0, 0, 8'h2A));
    endtask

    task automatic t_parity();
        // 0x35 in 7 bits has four ones
        set_cfg(2'd2, 0, 1, 0, 0);
        send(mk(8'h35, 7, 1, 0, 1, 1, 0), 10, 0);
        pop_expect("R5 even ok", ent(0, 0, 0, 0, 8'h35));
        send(mk(8'h35, 7, 1, 1, 1, 1, 0), 10, 0);
        pop_expect("R5 even bad", ent(0, 0, 1, 0, 8'h35));
        set_cfg(2'd2, 0, 1, 1, 0);
        send(mk(8'h35, 7, 1, 1, 1, 1, 0), 10, 0);
        pop_expect("R5 odd ok", ent(0, 0, 0, 0, 8'h35));
        send(mk(8'h35, 7, 1, 0, 1, 1, 0), 10, 0);
        pop_expect("R5 odd bad", ent(0, 0, 1, 0, 8'h35));
    endtask

    task automatic t_nine();
        set_cfg(2'd3, 0, 1, 1, 1);
        send(mk(8'h35, 8, 1, 1, 1, 1, 0), 11, 0);
        pop_expect("R6 address", ent(0, 0, 1, 0, 8'h35));
        send(mk(8'h35, 8, 1, 0, 1, 1, 0), 11, 0);
        pop_expect("R6 data", ent(0, 0, 0, 0, 8'h35));
        set_cfg(2'd3, 0, 0, 0, 1);
        send(mk(8'h00, 8, 1, 1, 1, 1, 0), 11, 0);
        pop_expect("R6 address no parity", ent(0, 0, 1, 0, 8'h00));
    endtask

    task automatic t_framing();
        set_cfg(2'd3, 0, 0, 0, 0);
        send(mk(8'hA5, 8, 0, 0, 1, 0, 0), 10, 1);
        pop_expect("R4 one stop low", ent(0, 0, 0, 1, 8'hA5));
        set_cfg(2'd3, 1, 0, 0, 0);
        send(mk(8'h5A, 8, 0, 0, 2, 1, 0), 11, 1);
        pop_expect("R4 second stop low", ent(0, 0, 0, 1, 8'h5A));
        send(mk(8'h5A, 8, 0, 0, 2, 1, 1), 11, 0);
        pop_expect("R4 two stops ok", ent(0, 0, 0, 0, 8'h5A));
        chk("R4 no extra entry", rd_valid == 1'b0, 32'(rd_valid), 32'd0);
    endtask

    task automatic t_glitch();
        set_cfg(2'd3, 0, 0, 0, 0);
        rx_line = 1'b0;
        repeat (8) @(negedge clk);
        rx_line = 1'b1;
        repeat (400) @(negedge clk);
        chk("R3 glitch rejected", rd_valid == 1'b0, 32'(rd_valid), 32'd0);
        send8(8'h99);
        pop_expect("R3 frame after glitch", ent(0, 0, 0, 0, 8'h99));
    endtask

    task automatic t_break();
        set_cfg(2'd3, 0, 0, 0, 0);
        rx_line = 1'b0;
        repeat (3 * 10 * BIT_CYC) @(negedge clk);
        rx_line = 1'b1;
        repeat (64) @(negedge clk);
        pop_expect("R7 break entry", ent(0, 1, 0, 1, 8'h00));
        chk("R7 single break entry", rd_valid == 1'b0, 32'(rd_valid), 32'd0);
        send8(8'h3C);
        pop_expect("R7 frame after break", ent(0, 0, 0, 0, 8'h3C));
    endtask

    task automatic t_overrun();
        set_cfg(2'd3, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) send8(8'(i + 16));
        chk("R8 full at 16", fifo_full == 1'b1, 32'(fifo_full), 32'd1);
        chk("R9 no sticky yet", ovr_sticky == 1'b0, 32'(ovr_sticky), 32'd0);
        send8(8'hEE);
        send8(8'hEF);
        chk("R9 sticky set", ovr_sticky == 1'b1, 32'(ovr_sticky), 32'd1);
        for (int i = 0; i < 16; i++) pop_expect("R9 kept entry", ent(0, 0, 0, 0, 8'(i + 16)));
        chk("R9 dropped not stored", rd_valid == 1'b0, 32'(rd_valid), 32'd0);
        chk("R11 sticky holds", ovr_sticky == 1'b1, 32'(ovr_sticky), 32'd1);
        send8(8'h55);
        send8(8'h66);
        pop_expect("R10 first after loss", ent(1, 0, 0, 0, 8'h55));
        pop_expect("R10 second after loss", ent(0, 0, 0, 0, 8'h66));
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
        chk("R11 cleared", ovr_sticky == 1'b0, 32'(ovr_sticky), 32'd0);
    endtask

    task automatic t_collide();
        bit seen;
        seen = 0;
        set_cfg(2'd3, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) send8(8'(i + 64));
        ovr_clr = 1'b1;
        fork
            send8(8'hD7);
            begin
                for (int k = 0; k < 10 * BIT_CYC + 40; k++) begin
                    @(negedge clk);
                    if (ovr_sticky) seen = 1;
                end
            end
        join
        ovr_clr = 1'b0;
        @(negedge clk);
        chk("R11 set wins over clear", seen == 1'b1, 32'(seen), 32'd1);
        chk("R11 clear after release", ovr_sticky == 1'b0, 32'(ovr_sticky), 32'd0);
        for (int i = 0; i < 16; i++) pop_expect("R9 kept entry", ent(0, 0, 0, 0, 8'(i + 64)));
        send8(8'h77);
        pop_expect("R10 marker survives clear", ent(1, 0, 0, 0, 8'h77));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_width();
        t_parity();
        t_nine();
        t_framing();
        t_glitch();
        t_break();
        t_overrun();
        t_collide();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("WATCHDOG FAIL all: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule